// File: doc/BRIEF.md
# Ethernet PHY Management Status Word

This block holds the 16-bit status word that an Ethernet PHY returns to a management station. Four live conditions come in from internal monitors: a valid link, finished auto-negotiation, a fault reported by the link partner, and jabber. The block places them in the word next to fixed capability bits. The condition bits are sticky, so that a short event stays visible until a read has seen it. Link status holds a drop. The other three conditions hold an occurrence. A completed management read releases every sticky bit, and each one then follows its live input again.

The frame decoder drives a one-cycle read-done pulse when the word has been shifted out. It drives a write pulse with a data word when a write targets this register. A write changes only the four speed and duplex ability bits. The write is rejected as a whole when any reserved bit in it is not zero. All other bits ignore writes. The word shown at `stat_word` is always the registered state, so what the station reads matches what the read pulse later releases.

Top module: `phy_stat_reg`

## Requirements
- R1: After reset `stat_word` equals 0x7809.
- R2: Bit 15, bits 10 to 7 and bit 6 always read 0, and bits 3 and 0 always read 1, whatever is written.
- R3: Bits 14..11 are the ability bits. They are, from 14 down, 100 Mb/s full duplex, 100 Mb/s half duplex, 10 Mb/s full duplex and 10 Mb/s half duplex. A write with reserved bits 10..7 all 0 loads `wr_data[14:11]` into them on the next clock edge.
- R4: A write with any of `wr_data[10:7]` set leaves bits 14..11 unchanged.
- R5: Bits 5 (auto-negotiation done), 4 (remote fault) and 1 (jabber) latch high. When the input is high at a clock edge, the bit reads 1 after that edge. It stays 1 until a read completes.
- R6: At a clock edge where `rd_done` is high, each latch-high bit takes the value of its input at that edge.
- R7: Bit 2 (link valid) latches low. When `link_ok` is low at a clock edge, the bit reads 0 after that edge. It stays 0 until a read completes.
- R8: At a clock edge where `rd_done` is high, bit 2 takes the value of `link_ok` at that edge.
- R9: A latching event that coincides with `rd_done` is kept. A high input on a latch-high bit, or a low `link_ok` on bit 2, shows in the word after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_done | input | 1 | One-cycle pulse: a management read of this word has completed |
| wr_en | input | 1 | One-cycle pulse: management write to this word |
| wr_data | input | 16 | Write data |
| link_ok | input | 1 | Live link-valid indication |
| an_done | input | 1 | Live auto-negotiation-complete indication |
| rmt_fault | input | 1 | Live remote-fault indication |
| jabber | input | 1 | Live jabber indication |
| stat_word | output | 16 | Status word presented to the read path |

## Verification
The hardest case to reach from the ports is a latching event that lands in the very cycle a read completes. Here the event has to win over the release. Random stimulus rarely lines up a one-cycle glitch with a read pulse on all four condition bits at once. The bench therefore forces that alignment in directed steps for each direction of latch. The random phase also holds `link_ok` mostly high and the other inputs mostly low, so isolated events and their release by later reads occur often.

// File: rtl/phy_stat_reg.sv
module phy_stat_reg #(
  parameter logic [3:0] CAP_RESET = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_done,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        link_ok,
  input  logic        an_done,
  input  logic        rmt_fault,
  input  logic        jabber,
  output logic [15:0] stat_word
);

  logic [3:0] cap_q;
  logic       an_q, rf_q, jb_q, lk_q;
  logic       wr_ok;
  logic       unused_wr_bits;

  assign wr_ok          = wr_en && (wr_data[10:7] == 4'b0);
  assign unused_wr_bits = ^{wr_data[15], wr_data[6:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= CAP_RESET;
    else if (wr_ok) cap_q <= wr_data[14:11];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      an_q <= 1'b0;
      rf_q <= 1'b0;
      jb_q <= 1'b0;
      lk_q <= 1'b0;
    end else if (rd_done) begin
      an_q <= an_done;
      rf_q <= rmt_fault;
      jb_q <= jabber;
      lk_q <= link_ok;
    end else begin
      an_q <= an_q | an_done;
      rf_q <= rf_q | rmt_fault;
      jb_q <= jb_q | jabber;
      lk_q <= lk_q & link_ok;
    end
  end

  assign stat_word = {1'b0, cap_q, 4'b0000, 1'b0, an_q, rf_q, 1'b1, lk_q, jb_q, 1'b1};

  p_bad_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[10:7] != 4'b0) |=> $stable(stat_word[14:11]));

  p_good_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[10:7] == 4'b0) |=> stat_word[14:11] == $past(wr_data[14:11]));

  p_high_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[1] && !rd_done) |=> stat_word[1]);

  p_low_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_word[2] && !rd_done) |=> !stat_word[2]);

  p_read_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> stat_word[5] == $past(an_done));

  p_read_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> stat_word[2] == $past(link_ok));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rmt_fault) |=> stat_word[4]);

endmodule

// File: tb/test_phy_stat_reg.sv
`timescale 1ns/1ps
module test_phy_stat_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_done = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic link_ok = 1'b0, an_done = 1'b0, rmt_fault = 1'b0, jabber = 1'b0;
  logic [15:0] stat_word;

  int checks = 0, fails = 0;
  logic [3:0] m_cap;
  logic m_an, m_rf, m_jb, m_lk;

  always #2 clk = ~clk;

  phy_stat_reg i_phy_stat_reg (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .wr_en(wr_en), .wr_data(wr_data),
    .link_ok(link_ok), .an_done(an_done), .rmt_fault(rmt_fault), .jabber(jabber),
    .stat_word(stat_word)
  );

  function automatic logic [15:0] model_word();
    return {1'b0, m_cap, 4'b0, 1'b0, m_an, m_rf, 1'b1, m_lk, m_jb, 1'b1};
  endfunction

  function automatic logic lh_next(logic q, logic in, logic rd);
    return rd ? in : (q | in);
  endfunction

  function automatic logic ll_next(logic q, logic in, logic rd);
    return rd ? in : (q & in);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [15:0] e = model_word();
    chk("R2 fixed bits", stat_word & 16'h87C9, e & 16'h87C9);
    chk("R3/R4 ability bits", {12'h0, stat_word[14:11]}, {12'h0, e[14:11]});
    chk("R5/R6/R9 latch-high bits", stat_word & 16'h0032, e & 16'h0032);
    chk("R7/R8/R9 link bit", stat_word & 16'h0004, e & 16'h0004);
  endtask

  task automatic cyc(logic rd, logic we, logic [15:0] wd, logic lk, logic an, logic rf, logic jb);
    @(negedge clk);
    rd_done = rd; wr_en = we; wr_data = wd;
    link_ok = lk; an_done = an; rmt_fault = rf; jabber = jb;
    @(posedge clk);
    if (we && wd[10:7] == 4'b0) m_cap = wd[14:11];
    m_an = lh_next(m_an, an, rd);
    m_rf = lh_next(m_rf, rf, rd);
    m_jb = lh_next(m_jb, jb, rd);
    m_lk = ll_next(m_lk, lk, rd);
    #1;
    check_all();
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1893));
    m_cap = 4'hF; m_an = 0; m_rf = 0; m_jb = 0; m_lk = 0;
    #10;
    chk("R1 reset word", stat_word, 16'h7809);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 reset word after release", stat_word, 16'h7809);

    cyc(0, 0, 16'h0, 1, 0, 0, 0);
    chk("R7 link stays low before read", stat_word & 16'h0004, 16'h0000);
    cyc(1, 0, 16'h0, 1, 0, 0, 0);
    chk("R8 read loads link", stat_word & 16'h0004, 16'h0004);
    cyc(0, 0, 16'h0, 0, 0, 0, 1);
    cyc(0, 0, 16'h0, 1, 0, 0, 0);
    chk("R5 jabber held", stat_word & 16'h0002, 16'h0002);
    chk("R7 link drop held", stat_word & 16'h0004, 16'h0000);
    cyc(1, 0, 16'h0, 1, 0, 0, 0);
    chk("R6 read releases jabber", stat_word & 16'h0002, 16'h0000);
    cyc(1, 0, 16'h0, 0, 1, 1, 1);
    chk("R9 events kept at read", stat_word & 16'h0036, 16'h0032);
    cyc(1, 0, 16'h0, 1, 1, 0, 0);
    chk("R6 read takes live inputs", stat_word, 16'h782D);
    cyc(0, 1, 16'h0400, 1, 0, 0, 0);
    chk("R4 reserved bit set rejects write", stat_word[14:11], 4'hF);
    cyc(0, 1, 16'hFFFF & ~16'h0780 & ~16'h4000, 1, 0, 0, 0);
    chk("R3 write loads abilities", {1'b0, stat_word[14:11]}, 5'h7);
    chk("R2 fixed bits after write", stat_word & 16'h87C9, 16'h0009);

    for (int i = 0; i < 3000; i++) begin
      logic rd = ($urandom % 4) == 0;
      logic we = ($urandom % 10) == 0;
      logic [15:0] wd = $urandom;
      if ($urandom % 2) wd[10:7] = 4'b0;
      cyc(rd, we, wd, ($urandom % 8) != 0, ($urandom % 6) == 0,
          ($urandom % 9) == 0, ($urandom % 7) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule